// File: doc/BRIEF.md
# Power-Good Pass-Through Sequencer

This block turns two board-level health indications, a system-wide power-good and a voltage-regulator-ready, into three ordered enables. These are a core-standby power-good, a hub power-OK and a system power-OK. The outputs come up one after another, with fixed millisecond gaps between them. A divider derives a millisecond tick from the system clock, and every delay and timeout in the block counts that tick. The divider restarts whenever the sequence enters a new stage, so each wait is an exact number of clock cycles.

After core-standby power-good is raised, the regulator-ready input is sampled once per millisecond for a bounded window. If the regulator never reports ready, the block abandons the sequence. It drops every output and raises a sticky timeout flag. That flag and the stalled state are cleared only when system power-good goes away. Loss of system power-good at any moment pulls all three outputs low in the same cycle. A new rise of system power-good then starts the chain again from its first stage.

Inputs are assumed to be synchronous to `clk`. All delays are parameters given in milliseconds, and `TICK_DIV` gives the number of clock cycles in one millisecond.

Top module: `pwrgood_chain`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released with `sys_pg` low, `core_pg`, `hub_ok`, `sys_ok` and `vr_timeout` are all 0.
- R2: Whenever `sys_pg` is 0, `core_pg`, `hub_ok` and `sys_ok` are 0 in that same cycle, with no clock edge needed. The internal stage registers are clear one edge later.
- R3: Call E0 the first rising clock edge that samples `sys_pg` high while the block is idle. `core_pg` rises on edge E0 + CORE_DLY_MS*TICK_DIV.
- R4: Call X the edge on which `core_pg` rises. `vr_rdy` is sampled only on edges X + k*TICK_DIV, for k = 1 to VR_TMO_MS. If the first sample that sees it high is sample k, `hub_ok` rises on edge X + (k + HUB_DLY_MS)*TICK_DIV.
- R5: If none of the VR_TMO_MS samples sees `vr_rdy` high, then on edge X + VR_TMO_MS*TICK_DIV `core_pg` falls and `vr_timeout` rises.
- R6: Call Y the edge on which `hub_ok` rises. `sys_ok` rises on edge Y + SYS_DLY_MS*TICK_DIV, and only if `sys_pg` is still high at that edge. If `sys_pg` has dropped before then, all outputs are low instead.
- R7: While `sys_pg` stays high and no timeout occurs, an output that has risen stays high, and no stage delay is served twice. Changes on `vr_rdy` after `hub_ok` has risen have no effect on any output.
- R8: `vr_timeout` stays set until `sys_pg` is sampled low. It reads 0 from the edge after that onward.
- R9: After a timeout, all three outputs stay low while `sys_pg` remains high. Only a fall and a new rise of `sys_pg` starts the sequence again, and it starts from the core-standby stage with the full delay of R3.
- R10: `hub_ok` is never high while `core_pg` is low, and `sys_ok` is never high while `hub_ok` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_pg | input | 1 | System-wide power-good indication |
| vr_rdy | input | 1 | Voltage regulator ready indication |
| core_pg | output | 1 | Core-standby power-good, first stage |
| hub_ok | output | 1 | Hub power-OK, second stage |
| sys_ok | output | 1 | System power-OK, final stage |
| vr_timeout | output | 1 | Sticky flag: regulator-ready wait expired |

## Verification
A state register or stage counter that is off by one tick shows up as an output edge landing whole milliseconds early or late. The bench therefore measures every rising edge to the exact cycle, starting from the stimulus that caused it. A stuck or wrongly decoded state shows either as an output that never rises, caught within the longest stage window, or as an output that survives a drop of `sys_pg`, caught in the same cycle. A timeout flag that is not sticky, or that fails to clear, is visible within one cycle of the timeout or of the next drop of `sys_pg`.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CORE   = 3'd1,
    ST_VRWAIT = 3'd2,
    ST_HUB    = 3'd3,
    ST_SYS    = 3'd4,
    ST_UP     = 3'd5,
    ST_STALL  = 3'd6
  } seq_state_e;

  // Largest of four millisecond limits, sizes the stage counter.
  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // Counter width holding values 0..n-1 (at least one bit).
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // True for the states that consume millisecond ticks.
  function automatic logic is_timed(input seq_state_e s);
    return (s == ST_CORE) || (s == ST_VRWAIT) || (s == ST_HUB) || (s == ST_SYS);
  endfunction

endpackage

// File: rtl/pgc_tick_gen.sv
module pgc_tick_gen #(
  parameter int unsigned TICK_DIV = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  import pgc_pkg::*;

  localparam int unsigned CW = cnt_width(TICK_DIV);
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] div_q;

  assign tick = (div_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              div_q <= '0;
    else if (restart || tick) div_q <= '0;
    else                     div_q <= div_q + 1'b1;
  end

  generate
    if (TICK_DIV > 1) begin : g_spacing
      // Ticks are at least one cycle apart (R3 timing base).
      p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/pgc_stage_timer.sv
module pgc_stage_timer #(
  parameter int unsigned CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          expire
);

  logic [CW-1:0] ms_q;

  assign expire = run && tick && (ms_q == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ms_q <= '0;
    else if (restart)      ms_q <= '0;
    else if (run && tick)  ms_q <= ms_q + 1'b1;
  end

  // A stage never counts past its own limit (R4 window bound).
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart) |-> (ms_q < limit));

endmodule

// File: rtl/pgc_seq_fsm.sv
module pgc_seq_fsm #(
  parameter int unsigned CORE_DLY_MS = 2,
  parameter int unsigned VR_TMO_MS   = 50,
  parameter int unsigned HUB_DLY_MS  = 2,
  parameter int unsigned SYS_DLY_MS  = 45,
  parameter int unsigned CW          = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sys_pg,
  input  logic          vr_rdy,
  input  logic          tick,
  input  logic          expire,
  output logic          stage_start,
  output logic          run,
  output logic [CW-1:0] limit,
  output logic          tmo_event,
  output logic          core_q,
  output logic          hub_q,
  output logic          sysok_q,
  output logic          vr_timeout_q
);
  import pgc_pkg::*;

  seq_state_e state_q, state_d;
  logic core_set, hub_set, sys_set;

  always_comb begin
    state_d   = state_q;
    tmo_event = 1'b0;
    core_set  = 1'b0;
    hub_set   = 1'b0;
    sys_set   = 1'b0;
    if (!sys_pg) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: state_d = ST_CORE;
        ST_CORE: if (expire) begin
          state_d  = ST_VRWAIT;
          core_set = 1'b1;
        end
        ST_VRWAIT: if (tick) begin
          if (vr_rdy) begin
            state_d = ST_HUB;
          end else if (expire) begin
            state_d   = ST_STALL;
            tmo_event = 1'b1;
          end
        end
        ST_HUB: if (expire) begin
          state_d = ST_SYS;
          hub_set = 1'b1;
        end
        // Final release is taken only inside the sys_pg-high branch.
        ST_SYS: if (expire) begin
          state_d = ST_UP;
          sys_set = 1'b1;
        end
        ST_UP:    state_d = ST_UP;
        ST_STALL: state_d = ST_STALL;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  assign stage_start = (state_d != state_q);
  assign run         = is_timed(state_q);

  always_comb begin
    unique case (state_q)
      ST_CORE:   limit = CW'(CORE_DLY_MS);
      ST_VRWAIT: limit = CW'(VR_TMO_MS);
      ST_HUB:    limit = CW'(HUB_DLY_MS);
      ST_SYS:    limit = CW'(SYS_DLY_MS);
      default:   limit = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      core_q       <= 1'b0;
      hub_q        <= 1'b0;
      sysok_q      <= 1'b0;
      vr_timeout_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (!sys_pg || tmo_event) begin
        core_q  <= 1'b0;
        hub_q   <= 1'b0;
        sysok_q <= 1'b0;
      end else begin
        if (core_set) core_q  <= 1'b1;
        if (hub_set)  hub_q   <= 1'b1;
        if (sys_set)  sysok_q <= 1'b1;
      end
      if (!sys_pg)        vr_timeout_q <= 1'b0;
      else if (tmo_event) vr_timeout_q <= 1'b1;
    end
  end

  p_clear_on_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_pg |=> (!core_q && !hub_q && !sysok_q));
  p_tmo_effect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_event |=> (vr_timeout_q && !core_q));
  p_release_after_hub_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sysok_q) |-> $past(hub_q) && $past(sys_pg));
  p_core_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (core_q && sys_pg && !tmo_event) |=> core_q);
  p_hub_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hub_q && sys_pg) |=> hub_q);
  p_sys_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sysok_q && sys_pg) |=> sysok_q);
  p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_pg |=> !vr_timeout_q);
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vr_timeout_q && sys_pg) |=> vr_timeout_q);
  p_stall_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STALL) |-> (!core_q && !hub_q && !sysok_q));
  p_order_hub_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hub_q |-> core_q);
  p_order_sys_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sysok_q |-> hub_q);

endmodule

// File: rtl/pwrgood_chain.sv
module pwrgood_chain #(
  parameter int unsigned TICK_DIV    = 100000,
  parameter int unsigned CORE_DLY_MS = 2,
  parameter int unsigned VR_TMO_MS   = 50,
  parameter int unsigned HUB_DLY_MS  = 2,
  parameter int unsigned SYS_DLY_MS  = 45
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sys_pg,
  input  logic vr_rdy,
  output logic core_pg,
  output logic hub_ok,
  output logic sys_ok,
  output logic vr_timeout
);
  import pgc_pkg::*;

  localparam int unsigned MAX_MS = max4(CORE_DLY_MS, VR_TMO_MS, HUB_DLY_MS, SYS_DLY_MS);
  localparam int unsigned MS_CW  = cnt_width(MAX_MS + 1);

  logic            tick;
  logic            expire;
  logic            stage_start;
  logic            run;
  logic [MS_CW-1:0] limit;
  logic            tmo_event;
  logic            core_q, hub_q, sysok_q;

  pgc_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (stage_start),
    .tick    (tick)
  );

  pgc_stage_timer #(.CW(MS_CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (stage_start),
    .run     (run),
    .tick    (tick),
    .limit   (limit),
    .expire  (expire)
  );

  pgc_seq_fsm #(
    .CORE_DLY_MS (CORE_DLY_MS),
    .VR_TMO_MS   (VR_TMO_MS),
    .HUB_DLY_MS  (HUB_DLY_MS),
    .SYS_DLY_MS  (SYS_DLY_MS),
    .CW          (MS_CW)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .sys_pg       (sys_pg),
    .vr_rdy       (vr_rdy),
    .tick         (tick),
    .expire       (expire),
    .stage_start  (stage_start),
    .run          (run),
    .limit        (limit),
    .tmo_event    (tmo_event),
    .core_q       (core_q),
    .hub_q        (hub_q),
    .sysok_q      (sysok_q),
    .vr_timeout_q (vr_timeout)
  );

  // Loss of system power-good removes every enable without waiting for a clock edge.
  assign core_pg = core_q  & sys_pg;
  assign hub_ok  = hub_q   & sys_pg;
  assign sys_ok  = sysok_q & sys_pg;

  p_rise_only_with_pg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_q) |-> $past(sys_pg));

endmodule

// File: tb/test_pwrgood_chain.sv
module test_pwrgood_chain;

  localparam int TD   = 8;
  localparam int CORE = 2;
  localparam int VR   = 50;
  localparam int HUB  = 2;
  localparam int SYSD = 45;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sys_pg = 1'b0;
  logic vr_rdy = 1'b0;
  logic core_pg, hub_ok, sys_ok, vr_timeout;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwrgood_chain #(
    .TICK_DIV(TD), .CORE_DLY_MS(CORE), .VR_TMO_MS(VR),
    .HUB_DLY_MS(HUB), .SYS_DLY_MS(SYSD)
  ) i_pwrgood_chain (
    .clk(clk), .rst_n(rst_n), .sys_pg(sys_pg), .vr_rdy(vr_rdy),
    .core_pg(core_pg), .hub_ok(hub_ok), .sys_ok(sys_ok), .vr_timeout(vr_timeout)
  );

  function automatic int obs();
    return {28'd0, vr_timeout, sys_ok, hub_ok, core_pg};
  endfunction

  // Index of the first millisecond sample that can see vr_rdy driven after v cycles.
  function automatic int first_sample(input int v);
    return (v + TD) / TD;
  endfunction

  // Expected {flag, sys, hub, core} c edges after core_pg rose.
  function automatic int expect_bits(input int c, input int k);
    if (k > VR) return (c >= VR * TD) ? 4'b1000 : 4'b0001;
    return 1 + ((c >= (k + HUB) * TD) ? 2 : 0) + ((c >= (k + HUB + SYSD) * TD) ? 4 : 0);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Raise sys_pg and measure the core-standby delay (R3).
  task automatic start_seq();
    int cnt;
    sys_pg = 1'b1;
    cnt = 0;
    while (!core_pg && cnt < CORE * TD + 10) begin
      @(posedge clk); @(negedge clk); cnt++;
    end
    chk("R3", "edges to core_pg", cnt, CORE * TD + 1);
  endtask

  task automatic drop_and_check();
    sys_pg = 1'b0;
    #1;
    chk("R2", "outputs on drop", obs() & 7, 0);
    @(posedge clk); @(negedge clk);
    chk("R8", "flag after drop", int'(vr_timeout), 0);
    vr_rdy = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic trial(input int v, input int drop_at, input int hold_ms, input string req);
    int k, last, vr_off;
    string r;
    start_seq();
    k = first_sample(v);
    last = (k > VR) ? (VR + hold_ms) * TD + 2 : (k + HUB + SYSD) * TD + 3;
    vr_off = (k + HUB) * TD + 2;
    if (v == 0) vr_rdy = 1'b1;
    for (int c = 1; c <= last; c++) begin
      @(posedge clk); @(negedge clk);
      r = req;
      if (k > VR && c > VR * TD) r = "R9";
      if (k <= VR && c > vr_off) r = "R7";  // vr_rdy removed after hub stage
      chk(r, "stage bits", obs(), expect_bits(c, k));
      if (c == v) vr_rdy = 1'b1;
      if (k <= VR && c == vr_off) vr_rdy = 1'b0;
      if (c == drop_at) break;
    end
    drop_and_check();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int dummy;
    dummy = $urandom(32'd20240611);
    repeat (4) @(negedge clk);
    chk("R1", "outputs in reset", obs(), 0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1", "outputs after reset", obs(), 0);

    // Directed: ready before sampling, ready on last sample, ready one cycle too late.
    trial(0, -1, 0, "R4");
    trial(VR * TD - 1, -1, 0, "R4");
    trial(VR * TD, -1, 20, "R5");
    // Drop in the final wait: system power-OK must never appear (R6).
    trial(0, (1 + HUB + 20) * TD, 0, "R6");
    // Drop during the core-standby delay, then a clean restart (R9).
    sys_pg = 1'b1;
    repeat (TD) @(posedge clk);
    @(negedge clk);
    chk("R10", "outputs mid core wait", obs(), 0);
    drop_and_check();
    trial(3 * TD, -1, 0, "R4");
    // Constrained random regulator delays and drop points.
    for (int t = 0; t < 22; t++) begin
      int v, d;
      v = int'($urandom_range(0, 55 * TD));
      d = ($urandom_range(0, 2) == 0) ? int'($urandom_range(1, 95 * TD)) : -1;
      trial(v, d, 2, (first_sample(v) > VR) ? "R5" : "R6");
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule